// File: doc/BRIEF.md
# Dual-Clock FIFO with Edge-Triggered Reset

This block moves words from a write clock domain to an unrelated read clock domain through a small dual-port storage array. Each side keeps its own pointer. The pointers are one bit wider than the address. Each pointer is passed to the other side in Gray code through a two-flop synchronizer. As a result, the full and empty flags are pessimistic. Empty only drops once the written word is certainly stored. Full only drops once the freed slot is certainly free. After a write, the read side sees the new word two read-clock edges after the write-clock edge that stored it.

The reset input acts on its rising edge, not on its level. The rise clears both sides at once, with no clock needed. While a side is held in this internal reset, its flag pins both read as asserted and its requests are ignored. Each side then counts `RST_CYC` edges of its own clock and leaves reset on its own, even if the reset input is still high. The reset input must stay high at least as long as the slower side's exit window. It must also return low before the next reset can be issued.

Top module: `xclk_fifo`

## Requirements
- R1: A rising edge on `rst_in` drives `full` and `empty` high at once, with no clock edge needed, and discards every stored word.
- R2: The write side leaves reset at the `RST_CYC`-th (default 4) rising `wr_clk` edge after the reset rise, even with `rst_in` still high. From then on `full` reads low on an empty FIFO.
- R3: The read side leaves reset at the `RST_CYC`-th rising `rd_clk` edge after the reset rise. Its pointer synchronizer starts capturing at the next read edge, so a word already written clears `empty` at read edge `RST_CYC`+2.
- R4: Requests made while a side is in its internal reset are ignored. Requests made once it has left reset are accepted, even while `rst_in` is still high.
- R5: Accepted words come out in write order. `rd_data` is registered and updates at the read-clock edge that accepts a read.
- R6: After a write into an empty FIFO, `empty` stays high through the first rising `rd_clk` edge after the write edge. It goes low after the second.
- R7: After a read from a full FIFO, `full` stays high through the first rising `wr_clk` edge after the read edge. It goes low after the second.
- R8: `full` rises right after the write edge that makes `DEPTH` words stored. A write while `full` is high is dropped.
- R9: A read while `empty` is high is dropped. `rd_data` and the read position are left unchanged.
- R10: `empty` is never low while no word is stored, and `full` is never low while `DEPTH` words are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_in | input | 1 | Asynchronous reset; its rising edge starts a reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| full | output | 1 | No free slot is certain (high during write-side reset) |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Last word read |
| empty | output | 1 | No stored word is certain (high during read-side reset) |

## Verification
A behavioural queue follows every accepted word and is compared with each read. Single isolated transfers pin down the exact edge at which each flag changes on each side. A fill-to-capacity run followed by extra writes shows whether overflow is really dropped. A read issued on an empty FIFO shows whether underflow is really dropped. Two long streams, one draining fast and one slow, keep the FIFO near empty and near full so that the conservative-flag bound is tested against drifting clock phases. A reset held high while the read clock is slowed separates a level-held reset from a fixed per-side exit count.

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int RST_CYC = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_in,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_XOR = {2'b11, {(AW-1){1'b0}}};

  logic [RST_CYC-1:0] wsh, rsh;
  logic wrst, rrst;
  logic [AW:0] wbin, wgray, rq1, rq2;
  logic [AW:0] rbin, rgray, wq1, wq2;
  logic [DW-1:0] mem [DEPTH];
  logic wr_go, rd_go;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  always_ff @(posedge wr_clk or negedge rst_in)
    if (!rst_in) wsh <= '0;
    else         wsh <= {wsh[RST_CYC-2:0], 1'b1};

  always_ff @(posedge rd_clk or negedge rst_in)
    if (!rst_in) rsh <= '0;
    else         rsh <= {rsh[RST_CYC-2:0], 1'b1};

  assign wrst  = rst_in & ~wsh[RST_CYC-1];
  assign rrst  = rst_in & ~rsh[RST_CYC-1];

  assign full  = wrst | (wgray == (rq2 ^ FULL_XOR));
  assign empty = rrst | (rgray == wq2);
  assign wr_go = wr_en & ~full;
  assign rd_go = rd_en & ~empty;

  always_ff @(posedge wr_clk or posedge wrst)
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge rd_clk or posedge rrst)
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_go) begin
        rbin  <= rbin + 1'b1;
        rgray <= to_gray(rbin + 1'b1);
      end
    end

  always_ff @(posedge rd_clk)
    if (rd_go) rd_data <= mem[rbin[AW-1:0]];

endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_in,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          empty,
  input logic [DW-1:0] rd_data,
  input logic          wrst,
  input logic          rrst,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin
);
  logic armed = 1'b0;
  always_ff @(posedge rst_in) armed <= 1'b1;

  a_r4_wr_held: assert property (@(posedge wr_clk) disable iff (!armed)
    wrst |-> (wbin == '0 && full));

  a_r4_rd_held: assert property (@(posedge rd_clk) disable iff (!armed)
    rrst |-> (rbin == '0 && empty));

  a_r8_no_overflow: assert property (@(posedge wr_clk) disable iff (wrst || !armed)
    (wr_en && full) |=> (wbin == $past(wbin)));

  a_r9_no_underflow: assert property (@(posedge rd_clk) disable iff (rrst || !armed)
    (rd_en && empty) |=> (rbin == $past(rbin) && rd_data == $past(rd_data)));

  a_r5_wr_step: assert property (@(posedge wr_clk) disable iff (wrst || !armed)
    (wbin == $past(wbin)) || (wbin == $past(wbin) + 1'b1));

  a_r5_rd_step: assert property (@(posedge rd_clk) disable iff (rrst || !armed)
    (rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_in(rst_in),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
  .rd_data(rd_data), .wrst(wrst), .rrst(rrst), .wbin(wbin), .rbin(rbin)
);

// File: tb/test_xclk_fifo.sv
module test_xclk_fifo;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_in = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic full, empty;
  logic [DW-1:0] rd_data;
  realtime rhalf = 3.0;
  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];

  xclk_fifo #(.DW(DW), .AW(AW), .RST_CYC(4)) i_xclk_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_in(rst_in),
    .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
  );

  always #4 wr_clk = ~wr_clk;
  initial begin
    #1.3;
    forever #(rhalf) rd_clk = ~rd_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge rst_in) q.delete();

  initial forever begin
    bit acc;
    logic [DW-1:0] d;
    @(negedge wr_clk);
    acc = wr_en && !full;
    d = wr_data;
    @(posedge wr_clk);
    if (acc) q.push_back(d);
    #1;
    if (q.size() >= DEPTH) chk(full === 1'b1, "R10 full with all slots used", full, 1);
  end

  initial forever begin
    bit acc;
    logic [DW-1:0] prev, exp;
    @(negedge rd_clk);
    acc = rd_en && !empty;
    prev = rd_data;
    @(posedge rd_clk);
    #1;
    if (acc) begin
      if (q.size() == 0) chk(1'b0, "R10 read accepted with nothing stored", 0, 1);
      else begin
        exp = q.pop_front();
        chk(rd_data === exp, "R5 read order", rd_data, exp);
      end
    end else chk(rd_data === prev, "R9 rd_data hold", rd_data, prev);
    if (q.size() == 0) chk(empty === 1'b1, "R10 empty with nothing stored", empty, 1);
  end

  task automatic wr_one(input logic [DW-1:0] d);
    @(posedge wr_clk); #1;
    wr_en = 1'b1;
    wr_data = d;
    @(negedge wr_clk);
    while (full) @(negedge wr_clk);
    @(posedge wr_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_one(output logic [DW-1:0] d);
    @(posedge rd_clk); #1;
    rd_en = 1'b1;
    @(negedge rd_clk);
    while (empty) @(negedge rd_clk);
    @(posedge rd_clk); #1;
    d = rd_data;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog R5 actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    bit wdone;
    #20.3;
    rst_in = 1'b1;
    #0.5;
    chk(full === 1'b1 && empty === 1'b1, "R1 flags on reset rise", {full, empty}, 3);
    repeat (10) @(posedge wr_clk);
    #1 rst_in = 1'b0;
    repeat (3) @(posedge wr_clk);
    #1;
    chk(full === 1'b0, "R1 reset state full", full, 0);
    chk(empty === 1'b1, "R1 reset state empty", empty, 1);

    // R6 empty latency
    wr_data = 8'h3C;
    wr_en = 1'b1;
    @(posedge wr_clk);
    fork begin #1 wr_en = 1'b0; end join_none
    @(posedge rd_clk); #0.5;
    chk(empty === 1'b1, "R6 empty after first read edge", empty, 1);
    @(posedge rd_clk); #0.5;
    chk(empty === 1'b0, "R6 empty after second read edge", empty, 0);
    rd_one(d);
    chk(d === 8'h3C, "R5 single word", d, 8'h3C);

    // R9 read while empty
    @(posedge rd_clk); #1;
    rd_en = 1'b1;
    repeat (4) @(posedge rd_clk);
    #1 rd_en = 1'b0;
    chk(rd_data === 8'h3C, "R9 rd_data after reads on empty", rd_data, 8'h3C);
    chk(empty === 1'b1, "R9 still empty", empty, 1);
    wr_one(8'h77);
    rd_one(d);
    chk(d === 8'h77, "R9 read position unchanged", d, 8'h77);

    // R8 fill and overflow
    for (int i = 0; i < DEPTH; i++) wr_one(8'h10 + 8'(i));
    chk(full === 1'b1, "R8 full after DEPTH writes", full, 1);
    @(posedge wr_clk); #1;
    wr_data = 8'hEE;
    wr_en = 1'b1;
    repeat (3) @(posedge wr_clk);
    #1 wr_en = 1'b0;
    chk(full === 1'b1, "R8 still full after dropped writes", full, 1);

    // R7 full release latency
    @(posedge rd_clk); #1;
    rd_en = 1'b1;
    @(posedge rd_clk);
    fork begin #1 rd_en = 1'b0; end join_none
    @(posedge wr_clk); #0.5;
    chk(full === 1'b1, "R7 full after first write edge", full, 1);
    @(posedge wr_clk); #0.5;
    chk(full === 1'b0, "R7 full after second write edge", full, 0);
    for (int i = 1; i < DEPTH; i++) begin
      rd_one(d);
      chk(d === 8'h10 + 8'(i), "R8 drained word", d, 8'h10 + i);
    end
    repeat (4) @(posedge rd_clk);
    #1 chk(empty === 1'b1, "R8 overflow words absent", empty, 1);

    // R5 R10 streaming, fast then slow drain
    for (int pass = 0; pass < 2; pass++) begin
      wdone = 1'b0;
      fork
        begin
          for (int i = 0; i < 150; i++) begin
            repeat ($urandom % 3) @(posedge wr_clk);
            wr_one(8'(i * 7 + pass * 91 + 3));
          end
          wdone = 1'b1;
        end
        begin
          while (!(wdone && q.size() == 0)) begin
            @(posedge rd_clk); #1;
            rd_en = (pass == 0) ? (($urandom % 3) != 0) : (($urandom % 5) == 0);
          end
          rd_en = 1'b0;
        end
      join
    end
    repeat (4) @(posedge rd_clk);

    // R2 R3 R4 held reset with slow read clock
    rhalf = 9.0;
    wr_one(8'hB1);
    wr_one(8'hB2);
    repeat (4) @(posedge rd_clk);
    @(posedge rd_clk); #1;
    rst_in = 1'b1;
    wr_data = 8'hA1;
    wr_en = 1'b1;
    #0.5;
    chk(full === 1'b1 && empty === 1'b1, "R1 flags on reset rise with data", {full, empty}, 3);
    fork
      begin
        for (int k = 1; k <= 7; k++) begin
          @(posedge wr_clk); #0.5;
          if (k == 3) chk(full === 1'b1, "R2 write side in reset at edge 3", full, 1);
          if (k == 4) chk(full === 1'b0, "R2 write side out at edge 4", full, 0);
          #0.5;
          wr_data = 8'hA0 + 8'(k + 1);
          if (k == 7) wr_en = 1'b0;
        end
      end
      begin
        for (int k = 1; k <= 6; k++) begin
          @(posedge rd_clk); #0.5;
          if (k == 3) chk(empty === 1'b1, "R3 read side in reset at edge 3", empty, 1);
          if (k == 5) chk(empty === 1'b1, "R3 empty at read edge 5", empty, 1);
          if (k == 6) chk(empty === 1'b0, "R3 empty clears at read edge 6", empty, 0);
        end
      end
    join
    rd_one(d);
    chk(d === 8'hA5, "R4 first word after reset window", d, 8'hA5);
    rd_one(d);
    chk(d === 8'hA6, "R4 second word", d, 8'hA6);
    rd_one(d);
    chk(d === 8'hA7, "R4 third word", d, 8'hA7);
    chk(rst_in === 1'b1, "R4 reset input still high", rst_in, 1);
    repeat (4) @(posedge rd_clk);
    #1 chk(empty === 1'b1, "R1 stale words discarded", empty, 1);
    rst_in = 1'b0;
    repeat (4) @(posedge wr_clk);
    #1 chk(full === 1'b0, "R2 full low after reset drop", full, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule